// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking two levels of translation tables in memory. A request supplies the virtual address, whether the access is a read or a write, and whether it comes from user or supervisor mode. Each mode has its own top-level table, located by a frame number on a static input. The walker first fetches a segment entry, which names the frame of a page table. It then fetches the page entry, which names the target frame and carries the access flags.

On success the block returns the physical address and a cache-inhibit flag. On failure it returns one of three fault codes. The walker keeps the referenced and modified flags of the page entry up to date. It writes the entry back only when one of those flags actually changes. Memory is reached through a port that has at most one request in flight. Every request, including a write, waits for a response strobe before the walk moves on.

Both table levels are 4 KB pages of 1024 four-byte entries. The top ten address bits index the segment table, the next ten bits index the page table, and the low twelve bits pass through as the byte offset.

Top module: `pt_walker`

## Requirements
- R1: During and after reset, `done` and `mem_req` are low and `fault` reads 0 until a request is accepted.
- R2: The first memory request of a walk is a read at address (base << 12) + 4 × vaddr[31:22]. The base is `super_base` when `req_super` is 1 and `user_base` otherwise.
- R3: If bit 1 of the segment entry is 0, the walk ends with fault code 1 (table fault) after exactly one memory request.
- R4: The second request is a read at (segment entry[31:12] << 12) + 4 × vaddr[21:12].
- R5: If the segment entry is valid but bit 0 of the page entry is 0, the walk ends with fault code 2 (page fault).
- R6: A write ends with fault code 3 (protection fault) when bit 2 is set in either entry and both entries are valid. A read ignores bit 2 in both entries.
- R7: A walk with no fault ends with code 0, `paddr` = {page entry[31:12], vaddr[11:0]}, and `cinh` = page entry bit 6.
- R8: On success the page entry gets bit 3 (referenced) set and, for a write, bit 4 (modified) set. The updated word is written back to the page entry address as a third request only if it differs from the fetched word. All other bits are kept.
- R9: A walk that ends in a fault issues no memory write.
- R10: After `mem_req` is raised, no further `mem_req` is issued before `mem_rvalid` has been seen.
- R11: Each accepted request produces exactly one single-cycle `done` pulse. `req_valid` is ignored while a walk is in progress, and the request fields are captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | 1 = supervisor mode, 0 = user |
| user_base | input | 20 | Frame number of the user segment table |
| super_base | input | 20 | Frame number of the supervisor segment table |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data (updated page entry) |
| mem_rvalid | input | 1 | Response strobe, for reads and writes |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| done | output | 1 | Walk finished; result valid this cycle |
| fault | output | 2 | 0 none, 1 table, 2 page, 3 protection |
| paddr | output | 32 | Translated physical address |
| cinh | output | 1 | Cache inhibit for the translated page |

## Verification
The assertions assume the memory side never sends `mem_rvalid` in the same cycle as the `mem_req` it answers, and never sends a response that was not asked for. They also assume the segment table base inputs stay stable for the whole walk. The bench memory model holds each response back by at least one clock after it samples a request. Its delay varies from one to three cycles. It answers exactly once per request, and the bench changes the base inputs only between walks. The sweep covers every combination of the valid and read-only flags of the segment entry and the valid, read-only, referenced, modified and cache-inhibit flags of the page entry. Each combination is run for both modes and both access types. During every walk the bench also raises a second request to confirm that it is ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;

  // Result classes reported at the end of a walk
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PTAB = 2'd1,
    FLT_PAGE = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  // Walk sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG_REQ,
    ST_SEG_WAIT,
    ST_PG_REQ,
    ST_PG_WAIT,
    ST_WB_REQ,
    ST_WB_WAIT
  } walk_state_e;

  // Flag positions inside table entries
  localparam int SEG_VALID_BIT = 1;
  localparam int PG_VALID_BIT  = 0;
  localparam int RO_BIT        = 2;
  localparam int REF_BIT       = 3;
  localparam int MOD_BIT       = 4;
  localparam int CINH_BIT      = 6;

endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import walk_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent,
  input  logic             is_write,
  input  logic             seg_ro_q,
  output logic             seg_valid,
  output logic             seg_ro,
  output fault_e           pg_fault,
  output logic [ENT_W-1:0] pte_upd,
  output logic             pte_changed
);

  // Segment-level decode
  assign seg_valid = ent[SEG_VALID_BIT];
  assign seg_ro    = ent[RO_BIT];

  // Page-level permission check
  always_comb begin
    if (!ent[PG_VALID_BIT]) begin
      pg_fault = FLT_PAGE;
    end else if (is_write && (seg_ro_q || ent[RO_BIT])) begin
      pg_fault = FLT_PROT;
    end else begin
      pg_fault = FLT_NONE;
    end
  end

  // Referenced / modified update
  always_comb begin
    pte_upd          = ent;
    pte_upd[REF_BIT] = 1'b1;
    if (is_write) begin
      pte_upd[MOD_BIT] = 1'b1;
    end
  end

  assign pte_changed = (pte_upd != ent);

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import walk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rvalid,
  input  logic   seg_valid,
  input  fault_e pg_fault,
  input  logic   pte_changed,
  output logic   ld_req,
  output logic   ld_seg,
  output logic   ld_pte,
  output logic   fin,
  output fault_e fin_fault,
  output logic   fin_from_pg,
  output logic   issue,
  output logic   issue_we,
  output logic   sel_seg
);

  walk_state_e st_q, st_n;

  // Next-state and control strobes
  always_comb begin
    st_n      = st_q;
    ld_req    = 1'b0;
    ld_seg    = 1'b0;
    ld_pte    = 1'b0;
    fin       = 1'b0;
    fin_fault = FLT_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_req = 1'b1;
          st_n   = ST_SEG_REQ;
        end
      end
      ST_SEG_REQ: st_n = ST_SEG_WAIT;
      ST_SEG_WAIT: begin
        if (rvalid) begin
          if (!seg_valid) begin
            fin       = 1'b1;
            fin_fault = FLT_PTAB;
            st_n      = ST_IDLE;
          end else begin
            ld_seg = 1'b1;
            st_n   = ST_PG_REQ;
          end
        end
      end
      ST_PG_REQ: st_n = ST_PG_WAIT;
      ST_PG_WAIT: begin
        if (rvalid) begin
          if (pg_fault != FLT_NONE) begin
            fin       = 1'b1;
            fin_fault = pg_fault;
            st_n      = ST_IDLE;
          end else if (pte_changed) begin
            ld_pte = 1'b1;
            st_n   = ST_WB_REQ;
          end else begin
            fin  = 1'b1;
            st_n = ST_IDLE;
          end
        end
      end
      ST_WB_REQ: st_n = ST_WB_WAIT;
      ST_WB_WAIT: begin
        if (rvalid) begin
          fin  = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

  assign issue       = (st_q == ST_SEG_REQ) || (st_q == ST_PG_REQ) || (st_q == ST_WB_REQ);
  assign issue_we    = (st_q == ST_WB_REQ);
  assign sel_seg     = (st_q == ST_SEG_REQ);
  assign fin_from_pg = (st_q == ST_PG_WAIT);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter  int PAGE_BITS = 12,
  localparam int IDX_W     = PAGE_BITS - 2,
  localparam int ADDR_W    = PAGE_BITS + 2 * IDX_W,
  localparam int FRAME_W   = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_super,
  input  logic [FRAME_W-1:0] user_base,
  input  logic [FRAME_W-1:0] super_base,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic               done,
  output logic [1:0]         fault,
  output logic [ADDR_W-1:0]  paddr,
  output logic               cinh
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Control and decode wiring
  logic               ld_req, ld_seg, ld_pte, fin, fin_from_pg;
  logic               issue, issue_we, sel_seg;
  fault_e             fin_fault, pg_fault;
  logic               seg_valid, seg_ro, pte_changed;
  logic [ADDR_W-1:0]  pte_upd;

  // Walk context registers
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q, sup_q;
  logic [FRAME_W-1:0] seg_frame_q;
  logic               seg_ro_q;
  logic [ADDR_W-1:0]  pte_q;

  pt_walk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (req_valid),
    .rvalid      (mem_rvalid),
    .seg_valid   (seg_valid),
    .pg_fault    (pg_fault),
    .pte_changed (pte_changed),
    .ld_req      (ld_req),
    .ld_seg      (ld_seg),
    .ld_pte      (ld_pte),
    .fin         (fin),
    .fin_fault   (fin_fault),
    .fin_from_pg (fin_from_pg),
    .issue       (issue),
    .issue_we    (issue_we),
    .sel_seg     (sel_seg)
  );

  pt_entry_check #(.ENT_W(ADDR_W)) u_check (
    .ent         (mem_rdata),
    .is_write    (wr_q),
    .seg_ro_q    (seg_ro_q),
    .seg_valid   (seg_valid),
    .seg_ro      (seg_ro),
    .pg_fault    (pg_fault),
    .pte_upd     (pte_upd),
    .pte_changed (pte_changed)
  );

  // Context capture with explicit enables
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      va_q        <= '0;
      wr_q        <= 1'b0;
      sup_q       <= 1'b0;
      seg_frame_q <= '0;
      seg_ro_q    <= 1'b0;
      pte_q       <= '0;
    end else begin
      if (ld_req) begin
        va_q  <= req_vaddr;
        wr_q  <= req_write;
        sup_q <= req_super;
      end
      if (ld_seg) begin
        seg_frame_q <= mem_rdata[ADDR_W-1:PAGE_BITS];
        seg_ro_q    <= seg_ro;
      end
      if (ld_pte) begin
        pte_q <= pte_upd;
      end
    end
  end

  // Memory request datapath
  logic [FRAME_W-1:0] base_sel;
  assign base_sel  = sup_q ? super_base : user_base;
  assign mem_req   = issue;
  assign mem_we    = issue_we;
  assign mem_wdata = pte_q;
  assign mem_addr  = sel_seg ? {base_sel, va_q[ADDR_W-1 -: IDX_W], 2'b00}
                             : {seg_frame_q, va_q[PAGE_BITS +: IDX_W], 2'b00};

  // Result registers
  logic [ADDR_W-1:0] fin_pte;
  assign fin_pte = fin_from_pg ? pte_upd : pte_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done  <= 1'b0;
      fault <= FLT_NONE;
      paddr <= '0;
      cinh  <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        fault <= fin_fault;
        if (fin_fault == FLT_NONE) begin
          paddr <= {fin_pte[ADDR_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
          cinh  <= fin_pte[CINH_BIT];
        end else begin
          paddr <= '0;
          cinh  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_we,
  input logic       wdata_ref,
  input logic       mem_rvalid,
  input logic       done,
  input logic [1:0] fault
);

  logic       pending_q;
  logic       wrote_q;
  logic [1:0] nreq_q;

  // Bookkeeping of the current walk, cleared at each result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      wrote_q   <= 1'b0;
      nreq_q    <= 2'd0;
    end else begin
      pending_q <= (pending_q && !mem_rvalid) || mem_req;
      if (done) begin
        wrote_q <= 1'b0;
        nreq_q  <= 2'd0;
      end else begin
        wrote_q <= wrote_q || (mem_req && mem_we);
        if (mem_req && nreq_q != 2'd3) begin
          nreq_q <= nreq_q + 2'd1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!mem_req && !done); // R1
    end
  end

  AST_PTAB_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd1) |-> (nreq_q == 2'd1)); // R3

  AST_WB_HAS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wdata_ref); // R8

  AST_WB_THIRD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (nreq_q == 2'd2)); // R8

  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> !wrote_q); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pending_q); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .wdata_ref  (mem_wdata[3]),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .fault      (fault)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        req_super;
  logic [19:0] user_base;
  logic [19:0] super_base;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] paddr;
  logic        cinh;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .user_base(user_base),
    .super_base(super_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .paddr(paddr), .cinh(cinh)
  );

  // 125 MHz
  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Memory model
  logic [31:0] mem [logic [31:0]];
  int          lat;
  int          n_req;
  int          n_wr;
  logic [31:0] req_addr [4];
  logic [31:0] wr_addr;
  logic [31:0] wr_data;

  initial begin
    logic [31:0] a;
    logic [31:0] rd;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        a = mem_addr;
        if (n_req < 4) req_addr[n_req] = a;
        n_req++;
        if (mem_we) begin
          mem[a]  = mem_wdata;
          n_wr++;
          wr_addr = a;
          wr_data = mem_wdata;
        end
        rd = mem.exists(a) ? mem[a] : 32'h0;
        repeat (lat) @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rd;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_walk(input int it, input bit sup, input bit wr,
                          input bit segv, input bit segro, input logic [4:0] pf);
    logic [9:0]  si, pi;
    logic [11:0] off;
    logic [31:0] va, seg_ent, pte, seg_a, pte_a, exp_new, exp_pa;
    logic [19:0] ptf, pgf, base;
    logic [1:0]  exp_f;
    bit          pv, pro, wb;
    int          t, n0;
    bit          quiet;

    si  = 10'((it * 7 + 3) % 1024);
    pi  = 10'((it * 13 + 5) % 1024);
    off = 12'((it * 97) % 4096);
    va  = {si, pi, off};
    ptf = 20'h10000 + 20'(it);
    pgf = 20'h80000 + 20'(it * 3);
    base = sup ? super_base : user_base;
    pv  = pf[0];
    pro = pf[1];

    // Segment entry: [31:12] frame, bit2 read-only, bit1 valid; bit0 set opposite to catch misuse
    seg_ent = {ptf, 8'h00, 1'b1, segro, segv, ~segv};
    // Page entry: [31:12] frame, bit6 inhibit, bit4 modified, bit3 referenced, bit2 read-only, bit0 valid
    pte = {pgf, 5'(it), pf[4], 1'b0, pf[3], pf[2], pro, ~pv, pv};
    seg_a = {base, si, 2'b00};
    pte_a = {ptf, pi, 2'b00};
    mem[seg_a] = seg_ent;
    mem[pte_a] = pte;

    if (!segv)                  exp_f = 2'd1;
    else if (!pv)               exp_f = 2'd2;
    else if (wr && (segro || pro)) exp_f = 2'd3;
    else                        exp_f = 2'd0;
    exp_new = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
    wb      = (exp_f == 2'd0) && (exp_new != pte);
    exp_pa  = {pgf, off};

    lat   = it % 3;
    n_req = 0;
    n_wr  = 0;
    for (int k = 0; k < 4; k++) req_addr[k] = 32'hDEAD_BEEF;

    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    req_super = sup;
    @(negedge clk);
    // Second request while busy: must be ignored (R11)
    req_vaddr = ~va;
    req_write = ~wr;
    req_super = ~sup;
    @(negedge clk);
    req_valid = 1'b0;

    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk_eq("R11 done seen", 32'(done), 32'd1);

    chk_eq("R2 segment entry address", req_addr[0], seg_a);
    if (exp_f == 2'd1) chk_eq("R3 table fault code", 32'(fault), 32'd1);
    else if (exp_f == 2'd2) chk_eq("R5 page fault code", 32'(fault), 32'd2);
    else if (exp_f == 2'd3) chk_eq("R6 protection fault code", 32'(fault), 32'd3);
    else begin
      chk_eq("R6 R7 no fault code", 32'(fault), 32'd0);
      chk_eq("R7 paddr", paddr, exp_pa);
      chk_eq("R7 cinh", 32'(cinh), 32'(pf[4]));
    end
    if (exp_f != 2'd1) chk_eq("R4 page entry address", req_addr[1], pte_a);
    chk_eq("R3 R8 request count", 32'(n_req), (exp_f == 2'd1) ? 32'd1 : (wb ? 32'd3 : 32'd2));
    if (exp_f != 2'd0) chk_eq("R9 no write on fault", 32'(n_wr), 32'd0);
    else begin
      chk_eq("R8 write count", 32'(n_wr), wb ? 32'd1 : 32'd0);
      if (wb) begin
        chk_eq("R8 write address", wr_addr, pte_a);
        chk_eq("R8 write data", wr_data, exp_new);
      end
    end
    chk_eq("R8 stored page entry", mem[pte_a], wb ? exp_new : pte);

    n0 = n_req;
    quiet = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (done) quiet = 1'b0;
    end
    chk_eq("R11 single done pulse", 32'(quiet), 32'd1);
    chk_eq("R11 no extra request", 32'(n_req), 32'(n0));
  endtask

  initial begin
    int it;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_vaddr  = '0;
    req_write  = 1'b0;
    req_super  = 1'b0;
    user_base  = 20'h00012;
    super_base = 20'h00345;
    lat        = 0;
    n_req      = 0;
    n_wr       = 0;
    repeat (5) @(negedge clk);
    chk_eq("R1 done in reset", 32'(done), 32'd0);
    chk_eq("R1 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 done after reset", 32'(done), 32'd0);
    chk_eq("R1 fault after reset", 32'(fault), 32'd0);
    chk_eq("R1 no request after reset", 32'(n_req), 32'd0);

    it = 0;
    for (int sup = 0; sup < 2; sup++)
      for (int wr = 0; wr < 2; wr++)
        for (int sb = 0; sb < 4; sb++)
          for (int pf = 0; pf < 32; pf++) begin
            run_walk(it, sup[0], wr[0], sb[0], sb[1], pf[4:0]);
            it++;
          end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule